// File: doc/BRIEF.md
# Strided Multi-Bank Access Sequencer

This block walks a vector of elements in memory, one element address per clock, from a base word address in steps of a programmable stride. Each element address is split into a bank number (the low address bits) and a word address within that bank, and the element is presented as a request on that bank's own lane, together with the in-bank address. Memory is interleaved over a power-of-two number of banks, and each lane carries its own independent address.

Each bank stays occupied for a fixed number of cycles after it is accessed. The sequencer keeps a countdown per bank. When the next element maps to a bank that is still counting down, the sequencer stalls and holds that element until the bank is free again. Unit stride over enough banks gives one element per clock. A stride that shares factors with the bank count visits fewer distinct banks before it comes back to the same one. If that number of banks is smaller than the busy time, the walk stalls. A one-cycle done pulse follows the last element.

Top module: `strided_bank_sequencer`

## Requirements
- R1: An element at word address A is presented on bank lane A mod NUM_BANKS, the low log2(NUM_BANKS) address bits. The lane carries the in-bank address A >> log2(NUM_BANKS). Lanes without a request show address zero.
- R2: Element i of an operation uses address (base + i*stride) mod 2^ADDR_W, and the element index output shows i while that element is pending or issuing.
- R3: At most one bank request is high in any cycle. With no conflict, elements issue on consecutive cycles, and the first one issues in the cycle after the start pulse is captured.
- R4: A bank accessed in cycle t is not requested again before cycle t + BUSY_CYCLES. It may be requested again exactly in that cycle.
- R5: While an operation is active and the pending element's bank is still busy, the stall output is high and no request is made. The element index and the pending address are held until the bank frees.
- R6: Done is high for exactly one cycle, the cycle after the last element issues. A start with element count zero issues nothing and gives done in the cycle after the start.
- R7: A start pulse that arrives while an operation is active, including in its final issue cycle, is ignored and does not change the sequence.
- R8: After reset there are no requests, stall and done are low, and the element index is zero.
- R9: For NUM_BANKS=4 and BUSY_CYCLES=3, an N-element walk with stride 1 completes its last issue in cycle N. A walk with stride 4 or 0 completes it in cycle 1+3(N-1). Stride 2 alternates over two banks, which is fewer than the busy time, so it also stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startPulse | input | 1 | Starts an operation when idle |
| baseAddr | input | ADDR_W | Word address of element 0 |
| strideWords | input | ADDR_W | Address step between elements (modulo 2^ADDR_W) |
| elemCount | input | CNT_W | Number of elements |
| bankReq | output | NUM_BANKS | Per-bank access request |
| bankAddr | output | NUM_BANKS*ROW_W | Per-bank in-bank address, lane b at bits b*ROW_W upward |
| elemIdx | output | CNT_W | Index of the pending or issuing element |
| stallFlag | output | 1 | Pending element blocked by a busy bank |
| doneFlag | output | 1 | One-cycle pulse after the last element |

## Verification
Two things can fall in the same cycle. One is a new start pulse. The other is either a bank-conflict stall or the final issue of a running walk. The bench raises start in a stall cycle of a stride-4 walk and again in the last issue cycle of a stride-1 walk. In both cases the expected per-cycle request, index and done values are those of the undisturbed walk, and no requests follow the done pulse. Beyond that, a sweep over strides and base addresses compares every cycle against a schedule computed in the bench from the busy-time rule.

// File: rtl/bank_seq_pkg.sv
package bank_seq_pkg;
  typedef struct packed {
    logic loadOp;  // capture operation parameters
    logic issue;   // pending element goes out this cycle
  } seqStrobe_t;
endpackage

// File: rtl/bank_seq_ctrl.sv
module bank_seq_ctrl
  import bank_seq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startPulse,
  input  logic [CNT_W-1:0] elemCount,
  input  logic             targetFree,
  output seqStrobe_t       strobe,
  output logic [CNT_W-1:0] elemIdx,
  output logic             stallFlag,
  output logic             doneFlag
);
  logic             active;
  logic [CNT_W-1:0] lastIdx;

  always_comb begin
    strobe.loadOp = startPulse && !active;
    strobe.issue  = active && targetFree;
    stallFlag     = active && !targetFree;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active   <= 1'b0;
      elemIdx  <= '0;
      lastIdx  <= '0;
      doneFlag <= 1'b0;
    end else begin
      doneFlag <= 1'b0;
      if (strobe.loadOp) begin
        active   <= (elemCount != '0);
        elemIdx  <= '0;
        lastIdx  <= elemCount - 1'b1;
        doneFlag <= (elemCount == '0);
      end else if (strobe.issue) begin
        if (elemIdx == lastIdx) begin
          active   <= 1'b0;
          doneFlag <= 1'b1;
        end else begin
          elemIdx <= elemIdx + 1'b1;
        end
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    doneFlag |=> !doneFlag); // R6
  AST_STALL_HOLDS_IDX: assert property (@(posedge clk) disable iff (!rstN)
    (stallFlag && !startPulse) |=> $stable(elemIdx)); // R5
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (active && startPulse && !targetFree) |=> $stable(elemIdx)); // R7
  AST_NO_STALL_DONE: assert property (@(posedge clk) disable iff (!rstN)
    !(stallFlag && doneFlag)); // R6
endmodule

// File: rtl/bank_seq_datapath.sv
module bank_seq_datapath
  import bank_seq_pkg::*;
#(
  parameter int NUM_BANKS   = 4,
  parameter int ADDR_W      = 12,
  parameter int BUSY_CYCLES = 3
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  seqStrobe_t                         strobe,
  input  logic [ADDR_W-1:0]                  baseAddr,
  input  logic [ADDR_W-1:0]                  strideWords,
  output logic                               targetFree,
  output logic [NUM_BANKS-1:0]               bankReq,
  output logic [NUM_BANKS*(ADDR_W-$clog2(NUM_BANKS))-1:0] bankAddr
);
  localparam int BANK_W = $clog2(NUM_BANKS);
  localparam int ROW_W  = ADDR_W - BANK_W;
  localparam int BUSY_W = $clog2(BUSY_CYCLES + 1);
  localparam logic [BUSY_W-1:0] RELOAD = BUSY_W'(BUSY_CYCLES - 1);

  logic [ADDR_W-1:0] curAddr;
  logic [ADDR_W-1:0] strideReg;
  logic [BANK_W-1:0] targetBank;
  logic [ROW_W-1:0]  targetRow;
  logic [NUM_BANKS-1:0] bankIdle;

  assign targetBank = curAddr[BANK_W-1:0];
  assign targetRow  = curAddr[ADDR_W-1:BANK_W];
  assign targetFree = bankIdle[targetBank];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr   <= '0;
      strideReg <= '0;
    end else if (strobe.loadOp) begin
      curAddr   <= baseAddr;
      strideReg <= strideWords;
    end else if (strobe.issue) begin
      curAddr <= curAddr + strideReg;
    end
  end

  for (genvar g = 0; g < NUM_BANKS; g++) begin : gBank
    logic [BUSY_W-1:0] busyCnt;
    logic              hit;
    assign hit         = strobe.issue && (targetBank == BANK_W'(g));
    assign bankIdle[g] = (busyCnt == '0);
    assign bankReq[g]  = hit;
    assign bankAddr[g*ROW_W +: ROW_W] = hit ? targetRow : '0;

    always_ff @(posedge clk) begin
      if (!rstN)              busyCnt <= '0;
      else if (hit)           busyCnt <= RELOAD;
      else if (busyCnt != '0) busyCnt <= busyCnt - 1'b1;
    end

    if (BUSY_CYCLES > 1) begin : gGap
      AST_BANK_GAP: assert property (@(posedge clk) disable iff (!rstN)
        bankReq[g] |=> !bankReq[g]); // R4
    end
  end

  AST_ONE_REQ: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(bankReq)); // R3
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.issue && !strobe.loadOp) |=> $stable(curAddr)); // R5
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.issue && !strobe.loadOp) |=> (curAddr == $past(curAddr) + strideReg)); // R2
endmodule

// File: rtl/strided_bank_sequencer.sv
module strided_bank_sequencer
  import bank_seq_pkg::*;
#(
  parameter int NUM_BANKS   = 4,
  parameter int ADDR_W      = 12,
  parameter int CNT_W       = 8,
  parameter int BUSY_CYCLES = 3
) (
  input  logic                                            clk,
  input  logic                                            rstN,
  input  logic                                            startPulse,
  input  logic [ADDR_W-1:0]                               baseAddr,
  input  logic [ADDR_W-1:0]                               strideWords,
  input  logic [CNT_W-1:0]                                elemCount,
  output logic [NUM_BANKS-1:0]                            bankReq,
  output logic [NUM_BANKS*(ADDR_W-$clog2(NUM_BANKS))-1:0] bankAddr,
  output logic [CNT_W-1:0]                                elemIdx,
  output logic                                            stallFlag,
  output logic                                            doneFlag
);
  seqStrobe_t strobe;
  logic       targetFree;

  bank_seq_ctrl #(.CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .elemCount(elemCount),
    .targetFree(targetFree), .strobe(strobe), .elemIdx(elemIdx),
    .stallFlag(stallFlag), .doneFlag(doneFlag)
  );

  bank_seq_datapath #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W),
                      .BUSY_CYCLES(BUSY_CYCLES)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .baseAddr(baseAddr),
    .strideWords(strideWords), .targetFree(targetFree),
    .bankReq(bankReq), .bankAddr(bankAddr)
  );

  AST_STALL_NO_REQ: assert property (@(posedge clk) disable iff (!rstN)
    stallFlag |-> (bankReq == '0)); // R5
endmodule

// File: tb/strided_bank_sequencer_test.sv
module strided_bank_sequencer_test;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 4;
  localparam int AW = 12;
  localparam int CW = 8;
  localparam int BUSY = 3;
  localparam int RW = AW - 2;

  logic clk = 0;
  logic rstN = 0;
  logic startPulse = 0;
  logic [AW-1:0] baseAddr = '0;
  logic [AW-1:0] strideWords = '0;
  logic [CW-1:0] elemCount = '0;
  logic [NB-1:0] bankReq;
  logic [NB*RW-1:0] bankAddr;
  logic [CW-1:0] elemIdx;
  logic stallFlag, doneFlag;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  int lastIssue;

  strided_bank_sequencer #(.NUM_BANKS(NB), .ADDR_W(AW), .CNT_W(CW),
                           .BUSY_CYCLES(BUSY)) uut (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .baseAddr(baseAddr),
    .strideWords(strideWords), .elemCount(elemCount), .bankReq(bankReq),
    .bankAddr(bankAddr), .elemIdx(elemIdx), .stallFlag(stallFlag),
    .doneFlag(doneFlag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: actual=%0d cycles expected=<100000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idleCheck(input string tag);
    check(bankReq == '0, {tag, " no request"}, bankReq, 0);
    check(!stallFlag, {tag, " stall"}, stallFlag, 0);
  endtask

  // Runs one operation; a start with other parameters is raised at cycle ignoreAt (0: none).
  task automatic runOp(input int base, input int stride, input int n, input int ignoreAt);
    int sched[64];
    int lastAcc[NB];
    int prev = 0;
    int p = 0;
    int last;
    for (int b = 0; b < NB; b++) lastAcc[b] = -100;
    for (int i = 0; i < n; i++) begin
      int a = (base + i * stride) & ((1 << AW) - 1);
      int b = a & (NB - 1);
      int t = prev + 1;
      if (lastAcc[b] + BUSY > t) t = lastAcc[b] + BUSY;  // R4 busy rule
      sched[i] = t; prev = t; lastAcc[b] = t;
    end
    last = (n == 0) ? 0 : sched[n-1];
    @(negedge clk);
    baseAddr = AW'(base); strideWords = AW'(stride); elemCount = CW'(n);
    startPulse = 1;
    for (int c = 1; c <= last + 3; c++) begin
      @(negedge clk);
      startPulse = 0;
      baseAddr = '0; strideWords = AW'(1); elemCount = CW'(2);
      if (p < n && sched[p] == c) begin
        int a = (base + p * stride) & ((1 << AW) - 1);
        int b = a & (NB - 1);
        check(bankReq == NB'(1 << b), "R1 bank lane", bankReq, 1 << b);
        check(bankAddr[b*RW +: RW] == RW'(a >> 2), "R1 in-bank address",
              bankAddr[b*RW +: RW], a >> 2);
        check(elemIdx == CW'(p), "R2 element index", elemIdx, p);
        check(!stallFlag, "R3 no stall on issue", stallFlag, 0);
        check(!doneFlag, "R6 done early", doneFlag, 0);
        lastIssue = c;
        p++;
      end else if (p < n) begin
        check(stallFlag, "R5 stall raised", stallFlag, 1);
        check(bankReq == '0, "R5 no request in stall", bankReq, 0);
        check(elemIdx == CW'(p), "R5 index held", elemIdx, p);
      end else if (c == last + 1) begin
        check(doneFlag, "R6 done pulse", doneFlag, 1);
        idleCheck("R6 done cycle");
      end else begin
        check(!doneFlag, "R6 single done / R7 no rerun", doneFlag, 0);
        idleCheck("R7 after done");
      end
      if (c == ignoreAt) begin
        startPulse = 1; baseAddr = AW'(3); strideWords = AW'(1); elemCount = CW'(9);
      end
    end
    startPulse = 0;
    for (int w = 0; w < BUSY + 1; w++) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check(bankReq == '0, "R8 reset request", bankReq, 0);
    check(!stallFlag, "R8 reset stall", stallFlag, 0);
    check(!doneFlag, "R8 reset done", doneFlag, 0);
    check(elemIdx == '0, "R8 reset index", elemIdx, 0);

    // Sweep strides and bases (R1-R6)
    for (int s = 0; s < 10; s++) begin
      runOp(0, s, 7, 0);
      runOp(5, s, 7, 0);
      runOp(1021, s, 7, 0);
    end
    runOp(9, (1 << AW) - 1, 6, 0);  // R2 negative stride with wrap
    runOp(4094, 3, 5, 0);           // R2 address wrap
    runOp(12, 5, 1, 0);             // R6 single element

    // R9 completion times
    runOp(0, 1, 8, 0);
    check(lastIssue == 8, "R9 unit stride timing", lastIssue, 8);
    runOp(0, 4, 8, 0);
    check(lastIssue == 1 + 3 * 7, "R9 stride 4 timing", lastIssue, 22);
    runOp(7, 0, 5, 0);
    check(lastIssue == 1 + 3 * 4, "R9 stride 0 timing", lastIssue, 13);
    runOp(0, 2, 6, 0);
    check(lastIssue > 6, "R9 stride 2 stalls", lastIssue, 7);

    // R6 zero count
    @(negedge clk);
    elemCount = '0; baseAddr = '0; strideWords = AW'(1); startPulse = 1;
    @(negedge clk);
    startPulse = 0;
    check(doneFlag, "R6 zero count done", doneFlag, 1);
    check(bankReq == '0, "R6 zero count no request", bankReq, 0);
    @(negedge clk);
    check(!doneFlag, "R6 zero count single pulse", doneFlag, 0);
    idleCheck("R6 zero count after");

    // R7 start during a stall and during the final issue
    runOp(2, 4, 4, 2);
    runOp(6, 1, 5, 5);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule